// File: doc/BRIEF.md
# SPI Register-File Slave for a Clock Peripheral

This block is the serial front end of a small timekeeping peripheral. A host reaches it over a four-wire SPI link with an active-high chip select. The first byte of every transaction is a header. Its top bit selects the direction and its lower seven bits give the start address. Every byte after the header moves to or from the next consecutive address, so one transaction can sweep across many registers.

Inside the block there are three kinds of target. The time and alarm registers belong to the neighbouring counting and alarm logic and are reached through a one-byte-per-access register port. The control, trickle-charge and 96-byte scratch memory registers are held locally. The status register reflects two alarm flags that come from outside. The block applies write protection, and it signals the alarm logic when a read of an alarm register should acknowledge that alarm.

SPI signals are oversampled by the system clock, so the link must run much slower than the core clock. At 200 MHz there are 50 core cycles in each half period of a 2 MHz serial clock.

Top module: `rtc_spi_regfile`

## Requirements
- R1: In the header byte, bit 7 = 1 starts a write transaction and bit 7 = 0 starts a read transaction. Bits 6:0 are the start address.
- R2: Each data byte after the header uses the next address. The address wraps from 0x7F to 0x00.
- R3: Serial clock idles low. MOSI is sampled on the falling edge. MISO changes on the rising edge. Each byte is sent most significant bit first.
- R4: Chip select is active high. When it falls, byte framing restarts, and a partly shifted byte causes no register access.
- R5: MISO is high impedance while chip select is low, and it is driven while chip select is high.
- R6: While control bit 6 (write protect) is 1, writes to every address except control (0x0F) are discarded. Control can always be written.
- R7: Control (0x0F) keeps bits 7, 6, 2, 1 and 0. Bits 5:3 read as 0. Its reset value is 0x40, so write protect is set after reset.
- R8: Status (0x10) reads as {6'b0, alarm_flags[1:0]}. Writes to it are discarded.
- R9: Addresses 0x12–0x1F read as 0x00, and writes to them are discarded.
- R10: Addresses 0x00–0x0E are forwarded to the register port. A write gives one ext_wr pulse per completed byte, carrying ext_addr = address[3:0] and the data. A read gives one ext_rd pulse when the byte begins, and returns ext_rdata.
- R11: A read of 0x07–0x0A pulses alarm_ack[0]. A read of 0x0B–0x0E pulses alarm_ack[1]. No other access pulses either bit.
- R12: Trickle (0x11) and the scratch memory (0x20–0x7F) store written bytes and return them on reads. The trickle value is presented on trickle_o, with reset value 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host; high impedance when not selected |
| ext_wr | output | 1 | Write strobe to the time/alarm registers |
| ext_rd | output | 1 | Read strobe to the time/alarm registers |
| ext_addr | output | 4 | Time/alarm register index |
| ext_wdata | output | 8 | Write data to the time/alarm registers |
| ext_rdata | input | 8 | Read data from the time/alarm registers, valid in the same cycle |
| alarm_flags | input | 2 | Alarm flags shown in the status register |
| alarm_ack | output | 2 | One-cycle acknowledge per alarm on an alarm-register read |
| ctrl_o | output | 8 | Current control register |
| trickle_o | output | 8 | Current trickle register |

## Verification
The bench builds the block with its default parameters. With those defaults, write protect is set out of reset, so the first writes show the protection gate before any unlock. A two-stage synchronizer is used, and the serial clock runs at 2 MHz, which is 50 core cycles per half period. At that speed, the fetch at the start of each byte and the MSB-first shift-out can be checked at the fastest supported serial rate. Bursts are started at 0x0F and at 0x7E, so one transaction crosses the control/status/trickle/unmapped boundaries and another wraps from memory back into the time registers. A chip-select drop partway through a byte shows that framing restarts.

// File: rtl/rtc_spi_pkg.sv
`timescale 1ns/1ps
// Package: shared address map, region type and decoder for the SPI register file.
// Assumes a 7-bit address space as carried in the header byte.
package rtc_spi_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ALM0_BASE = 7'h07;
    localparam logic [ADDR_W-1:0] ALM1_BASE = 7'h0B;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
    localparam logic [ADDR_W-1:0] TRKL_ADDR = 7'h11;
    localparam logic [ADDR_W-1:0] MEM_BASE  = 7'h20;
    localparam int MEM_DEPTH = (1 << ADDR_W) - int'(MEM_BASE);
    localparam int WP_BIT    = 6;

    typedef enum logic [2:0] {
        RGN_TIME, RGN_ALM0, RGN_ALM1, RGN_CTRL,
        RGN_STAT, RGN_TRKL, RGN_HOLE, RGN_MEM
    } region_e;

    // Map an address to the region that owns it.
    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a < ALM0_BASE)      return RGN_TIME;
        else if (a < ALM1_BASE) return RGN_ALM0;
        else if (a < CTRL_ADDR) return RGN_ALM1;
        else if (a == CTRL_ADDR) return RGN_CTRL;
        else if (a == STAT_ADDR) return RGN_STAT;
        else if (a == TRKL_ADDR) return RGN_TRKL;
        else if (a < MEM_BASE)  return RGN_HOLE;
        else                    return RGN_MEM;
    endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
`timescale 1ns/1ps
// Module: brings SCLK, CS and MOSI into the core clock domain and detects
// SCLK edges. Assumes the core clock is many times faster than SCLK.
// Edges are only reported while the synchronized chip select is high.
module rtc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_last;

    assign raw = {sclk_i, cs_i, mosi_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        logic [STAGES-1:0] pipe;
        // Shift each input through its own synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= synced[2];
    end

    assign cs_act    = synced[1];
    assign mosi_s    = synced[0];
    assign sclk_rise = cs_act &  synced[2] & ~sclk_last;
    assign sclk_fall = cs_act & ~synced[2] &  sclk_last;
endmodule

// File: rtl/rtc_spi_shift.sv
`timescale 1ns/1ps
// Module: byte framing for an SPI slave with idle-low clock and sampling on
// the second edge. Samples MOSI on falling edges and shifts MISO out on
// rising edges, MSB first. Framing restarts whenever chip select is low.
module rtc_spi_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rise,
    input  logic          fall,
    input  logic          mosi_s,
    input  logic [DW-1:0] tx_load,
    output logic          byte_start,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          miso_bit
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [CW-1:0] bit_cnt;
    logic [DW-2:0] rx_sr;
    logic [DW-2:0] tx_sr;
    logic          miso_q;

    assign byte_start = rise & (bit_cnt == '0);
    assign byte_done  = fall & (bit_cnt == LAST);
    assign rx_byte    = {rx_sr, mosi_s};
    assign miso_bit   = miso_q;

    // Count bits, collect MOSI on falls, emit the next MISO bit on rises.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (fall) begin
                rx_sr   <= {rx_sr[DW-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (rise) begin
                if (bit_cnt == '0) begin
                    miso_q <= tx_load[DW-1];
                    tx_sr  <= tx_load[DW-2:0];
                end else begin
                    miso_q <= tx_sr[DW-2];
                    tx_sr  <= {tx_sr[DW-3:0], 1'b0};
                end
            end
        end
    end

    // R4: deselect clears the bit position before the next transaction.
    p_frame_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt == '0))
        else $error("bit counter not cleared by deselect");
endmodule

// File: rtl/rtc_spi_regs.sv
`timescale 1ns/1ps
// Module: register space behind the SPI slave. Holds control, trickle and
// scratch memory; forwards time/alarm accesses; applies write protection;
// raises alarm acknowledges on alarm-register reads. One access per cycle.
module rtc_spi_regs
    import rtc_spi_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RESET = 8'h40,
    parameter logic [DATA_W-1:0] CTRL_KEEP  = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [1:0]        alarm_flags,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [3:0]        ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic [1:0]        alarm_ack,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] trickle_q
);
    localparam int IDX_W = $clog2(MEM_DEPTH);

    region_e          rgn;
    logic             is_ext;
    logic             wr_ok;
    logic [IDX_W-1:0] mem_idx;
    logic [DATA_W-1:0] mem [MEM_DEPTH];

    assign rgn     = region_of(acc_addr);
    assign is_ext  = (rgn == RGN_TIME) || (rgn == RGN_ALM0) || (rgn == RGN_ALM1);
    assign wr_ok   = acc_wr & ~ctrl_q[WP_BIT];
    assign mem_idx = IDX_W'(acc_addr - MEM_BASE);

    assign ext_wr    = wr_ok & is_ext;
    assign ext_rd    = acc_rd & is_ext;
    assign ext_addr  = acc_addr[3:0];
    assign ext_wdata = acc_wdata;
    assign alarm_ack = {acc_rd & (rgn == RGN_ALM1), acc_rd & (rgn == RGN_ALM0)};

    // Control is writable regardless of protection; trickle obeys it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RESET & CTRL_KEEP;
            trickle_q <= '0;
        end else begin
            if (acc_wr && rgn == RGN_CTRL) ctrl_q    <= acc_wdata & CTRL_KEEP;
            if (wr_ok  && rgn == RGN_TRKL) trickle_q <= acc_wdata;
        end
    end

    // Scratch memory keeps its contents across reset.
    always_ff @(posedge clk) begin
        if (wr_ok && rgn == RGN_MEM) mem[mem_idx] <= acc_wdata;
    end

    // Select read data for the addressed region.
    always_comb begin
        case (rgn)
            RGN_TIME, RGN_ALM0, RGN_ALM1: rd_data = ext_rdata;
            RGN_CTRL: rd_data = ctrl_q;
            RGN_STAT: rd_data = {{(DATA_W-2){1'b0}}, alarm_flags};
            RGN_TRKL: rd_data = trickle_q;
            RGN_MEM:  rd_data = mem[mem_idx];
            default:  rd_data = '0;
        endcase
    end

    // R7: bits outside the kept set never become 1.
    p_ctrl_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0)
        else $error("control pad bits set");

    // R6: with protection set, the trickle register cannot change next cycle.
    p_wp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[WP_BIT] |=> $stable(trickle_q))
        else $error("trickle written under protection");

    // R11: an acknowledge only accompanies a forwarded read.
    p_ack_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|alarm_ack) |-> (ext_rd && !ext_wr))
        else $error("alarm acknowledge without forwarded read");
endmodule

// File: rtl/rtc_spi_regfile.sv
`timescale 1ns/1ps
// Module: top of the SPI register-file slave. Interprets the header byte,
// keeps the auto-incrementing burst address and issues one register access
// per data byte: reads at the first rising edge of the byte, writes when the
// byte completes. Assumes SCLK is at most a small fraction of clk.
module rtc_spi_regfile
    import rtc_spi_pkg::*;
#(
    parameter logic [7:0] CTRL_RESET  = 8'h40,
    parameter logic [7:0] CTRL_KEEP   = 8'hC7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       ext_wr,
    output logic       ext_rd,
    output logic [3:0] ext_addr,
    output logic [7:0] ext_wdata,
    input  logic [7:0] ext_rdata,
    input  logic [1:0] alarm_flags,
    output logic [1:0] alarm_ack,
    output logic [7:0] ctrl_o,
    output logic [7:0] trickle_o
);
    logic              sclk_rise, sclk_fall, cs_act, mosi_s;
    logic              byte_start, byte_done, miso_bit;
    logic [DATA_W-1:0] rx_byte, tx_load, rd_data;
    logic              in_data, wr_mode;
    logic [ADDR_W-1:0] addr_q;
    logic              acc_wr, acc_rd;

    rtc_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_i(spi_cs),
        .mosi_i(spi_mosi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .mosi_s(mosi_s)
    );

    rtc_spi_shift #(.DW(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .active(cs_act), .rise(sclk_rise),
        .fall(sclk_fall), .mosi_s(mosi_s), .tx_load(tx_load),
        .byte_start(byte_start), .byte_done(byte_done),
        .rx_byte(rx_byte), .miso_bit(miso_bit)
    );

    rtc_spi_regs #(.CTRL_RESET(CTRL_RESET), .CTRL_KEEP(CTRL_KEEP)) regs_i (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(addr_q), .acc_wdata(rx_byte), .rd_data(rd_data),
        .ext_rdata(ext_rdata), .alarm_flags(alarm_flags),
        .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .alarm_ack(alarm_ack),
        .ctrl_q(ctrl_o), .trickle_q(trickle_o)
    );

    assign acc_wr  = byte_done  & in_data &  wr_mode;
    assign acc_rd  = byte_start & in_data & ~wr_mode;
    assign tx_load = acc_rd ? rd_data : '0;
    assign spi_miso = spi_cs ? miso_bit : 1'bz;

    // Header capture, direction and burst address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data <= 1'b0;
            wr_mode <= 1'b0;
            addr_q  <= '0;
        end else if (!cs_act) begin
            in_data <= 1'b0;
        end else if (byte_done && !in_data) begin
            in_data <= 1'b1;
            wr_mode <= rx_byte[DATA_W-1];
            addr_q  <= rx_byte[ADDR_W-1:0];
        end else if (acc_wr || acc_rd) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    // R10: never a read and a write in the same cycle.
    p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && acc_rd))
        else $error("simultaneous read and write access");

    // R2: every access advances the address by one, modulo 128.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr || acc_rd) |=> (addr_q == $past(addr_q) + 1'b1))
        else $error("burst address did not advance");

    // R1: header bit 7 becomes the transaction direction.
    p_hdr_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !in_data) |=> (wr_mode == $past(rx_byte[DATA_W-1])))
        else $error("direction not taken from header");
endmodule

// File: tb/rtc_spi_regfile_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Read tasks queue expected bytes; a monitor pops
// them against received bytes. Port-level checks use the same counters.
module rtc_spi_regfile_tb_top;
    localparam int HALF = 50;   // core cycles per SCLK half period: 2 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       ext_wr, ext_rd;
    logic [3:0] ext_addr;
    logic [7:0] ext_wdata, ext_rdata;
    logic [1:0] alarm_flags = 2'b00;
    logic [1:0] alarm_ack;
    logic [7:0] ctrl_o, trickle_o;

    logic [7:0] ext_mem [16];
    int ext_wr_cnt = 0, ack0_cnt = 0, ack1_cnt = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    logic [7:0] pl[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_spi_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ext_wr(ext_wr),
        .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .alarm_flags(alarm_flags),
        .alarm_ack(alarm_ack), .ctrl_o(ctrl_o), .trickle_o(trickle_o)
    );

    // Model of the time/alarm registers owned by the neighbouring logic.
    assign ext_rdata = ext_mem[ext_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ext_mem[i] <= 8'h00;
        end else begin
            if (ext_wr) begin
                ext_mem[ext_addr] <= ext_wdata;
                ext_wr_cnt <= ext_wr_cnt + 1;
            end
            if (alarm_ack[0]) ack0_cnt <= ack0_cnt + 1;
            if (alarm_ack[1]) ack1_cnt <= ack1_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Monitor: compare each received read byte with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0)
                check(tag_q.pop_front(), {24'h0, got_q.pop_front()}, {24'h0, exp_q.pop_front()});
        end
    end

    task automatic cs_on();
        @(negedge clk); spi_cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        spi_cs = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // Shift nbits of tx, MSB first; drive on rise, sample MISO before fall.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            @(negedge clk); spi_sclk = 1'b1; spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic wr_burst(input logic [6:0] a);
        logic [7:0] r;
        cs_on();
        xfer({1'b1, a}, 8, r);
        while (pl.size() > 0) xfer(pl.pop_front(), 8, r);
        cs_off();
    endtask

    task automatic rd_burst(input logic [6:0] a, input string tag);
        logic [7:0] r;
        cs_on();
        xfer({1'b0, a}, 8, r);
        while (pl.size() > 0) begin
            exp_q.push_back(pl.pop_front());
            tag_q.push_back(tag);
            xfer(8'h00, 8, r);
            got_q.push_back(r);
        end
        cs_off();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R4 got=hung exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        int c0, c1, w0;
        logic [7:0] r;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        check("R5 reset miso z", {31'h0, spi_miso === 1'bz}, 1);
        check("R7 reset control", ctrl_o, 8'h40);
        check("R11 reset ack", alarm_ack, 0);
        check("R12 reset trickle", trickle_o, 0);

        pl = '{8'h40}; rd_burst(7'h0F, "R1 R3 R7 read control");

        // R6: protected writes to memory, trickle and a time register.
        w0 = ext_wr_cnt;
        pl = '{8'h99}; wr_burst(7'h11);
        pl = '{8'h12}; wr_burst(7'h00);
        check("R6 trickle blocked", trickle_o, 8'h00);
        check("R6 ext write blocked", ext_wr_cnt, w0);
        pl = '{8'h00}; wr_burst(7'h0F);
        check("R6 control writable under protect", ctrl_o, 8'h00);

        pl = '{8'hFF}; wr_burst(7'h0F);
        check("R7 control keep mask", ctrl_o, 8'hC7);
        pl = '{8'hC7}; rd_burst(7'h0F, "R7 control readback");
        pl = '{8'h00}; wr_burst(7'h0F);

        pl = '{8'hA5, 8'h5A, 8'h3C}; wr_burst(7'h20);
        pl = '{8'hA5, 8'h5A, 8'h3C}; rd_burst(7'h20, "R12 R2 memory burst");
        pl = '{8'hA9}; wr_burst(7'h11);
        check("R12 trickle written", trickle_o, 8'hA9);

        pl = '{8'h40}; wr_burst(7'h0F);
        pl = '{8'hFF}; wr_burst(7'h20);
        pl = '{8'h00}; wr_burst(7'h0F);
        pl = '{8'hA5}; rd_burst(7'h20, "R6 memory protected");

        // R10: time burst forwarded to the register port.
        w0 = ext_wr_cnt;
        pl = '{8'h30, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99}; wr_burst(7'h00);
        check("R10 ext write count", ext_wr_cnt, w0 + 7);
        check("R10 ext hour byte", ext_mem[2], 8'h23);
        pl = '{8'h30, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99}; rd_burst(7'h00, "R10 R3 time readback");

        // R2: wrap from the top of memory into address 0.
        pl = '{8'h11, 8'h22, 8'h33}; wr_burst(7'h7E);
        check("R2 wrap lands on addr 0", ext_mem[0], 8'h33);
        pl = '{8'h11, 8'h22, 8'h33}; rd_burst(7'h7E, "R2 wrap readback");

        // R8 / R9: status, holes.
        alarm_flags = 2'b10;
        pl = '{8'hEE}; wr_burst(7'h15);
        pl = '{8'hFF}; wr_burst(7'h10);
        pl = '{8'h00, 8'h02, 8'hA9, 8'h00, 8'h00}; rd_burst(7'h0F, "R8 R9 control-status-trickle-hole");
        pl = '{8'h00, 8'h00, 8'h00}; rd_burst(7'h14, "R9 hole reads zero");
        check("R8 status write no side effect", ctrl_o, 8'h00);

        // R11: alarm acknowledges.
        c0 = ack0_cnt; c1 = ack1_cnt;
        pl = '{8'h00}; rd_burst(7'h07, "R11 alarm0 read");
        check("R11 ack0 once", ack0_cnt, c0 + 1);
        check("R11 no ack1 on alarm0", ack1_cnt, c1);
        pl = '{8'h00, 8'h00}; rd_burst(7'h0B, "R11 alarm1 read");
        check("R11 ack1 twice", ack1_cnt, c1 + 2);
        pl = '{8'h33}; rd_burst(7'h00, "R11 time read");
        check("R11 no ack on time read", ack0_cnt + ack1_cnt, c0 + 1 + c1 + 2);

        // R4: aborted byte performs no write.
        cs_on();
        xfer(8'hA1, 8, r);
        xfer(8'hFF, 4, r);
        cs_off();
        pl = '{8'h5A}; rd_burst(7'h21, "R4 partial byte discarded");

        // R5: driven while selected, released after.
        cs_on();
        check("R5 miso driven when selected", {31'h0, spi_miso === 1'b0}, 1);
        cs_off();
        check("R5 miso z when deselected", {31'h0, spi_miso === 1'bz}, 1);

        repeat (20) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule